// File: doc/BRIEF.md
# Interrupt Request Flag Register with Bitwise Set/Clear Writes

This block collects single-cycle event pulses from a reader front end into a bank of sticky request flags. The sources are a timer expiry, transmit end, receive end, command idle, and the FIFO high and low alerts. A second register of the same width holds one enable bit per flag. The block ORs every flag that has its enable set into one global request. That request drives an interrupt pin, and software can program both the pin's polarity and its drive style.

Software never needs a read-modify-write to change a flag or an enable. Each written byte carries a selector in its top bit:

- When the selector is 1, every lower bit written as 1 is set.
- When the selector is 0, every lower bit written as 1 is cleared.
- Bits written as 0 keep their value.

An external decoder supplies separate write strobes for the request register, the enable register and the pin configuration register. All three share one write-data bus.

Top module: `irq_req_ctrl`

## Requirements
- R1: A write whose bit 7 is 1 sets every flag whose bit is 1 in data bits 5:0.
- R2: A write whose bit 7 is 0 clears every flag whose bit is 1 in data bits 5:0, unless an event for that flag arrives in the same cycle.
- R3: Flags whose mask bit is 0 are unchanged by a write. Writing 81h sets only bit 0, and writing 3Fh clears all six flags.
- R4: The request flags sit at fixed bit positions: bit 5 is timer, bit 4 is transmit end, bit 3 is receive end, bit 2 is idle, bit 1 is FIFO high alert and bit 0 is FIFO low alert. Readback bits 7 and 6 are always 0, even after a write of FFh.
- R5: After reset, the request readback is 00h, the enable readback is 00h and the pin configuration readback is 02h.
- R6: A pulse on an event input sets its flag, and the flag stays set until it is cleared by a write. When an event and a clear hit the same flag in the same cycle, the event wins.
- R7: The enable register uses the same set/clear write rule as the request register, with the same bit positions.
- R8: `irq_global` is 1 exactly when at least one flag and its enable are both 1.
- R9: Pin configuration bit 0 is the invert control. The pin level is `irq_global` XOR bit 0. Configuration bits 7:2 read as 0.
- R10: Pin configuration bit 1 selects the drive mode.
  - When bit 1 is 1 (push-pull), the output enable is always 1 and the output follows the pin level.
  - When bit 1 is 0 (open-drain), the output is 0 and the output enable is 1 only while the pin level is low.
- R11: A write or an event takes effect on the clock edge where it is sampled, and it is visible on the outputs from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_wr | input | 1 | Write strobe for the request flag register |
| en_wr | input | 1 | Write strobe for the enable register |
| cfg_wr | input | 1 | Write strobe for the pin configuration register |
| wdata | input | 8 | Write data; bit 7 selects set (1) or clear (0) for the flag and enable registers |
| evt | input | 6 | Event pulses, at the same bit positions as the flags (R4) |
| req_rd | output | 8 | Request flag readback |
| en_rd | output | 8 | Enable readback |
| cfg_rd | output | 8 | Pin configuration readback |
| irq_global | output | 1 | OR of the flags that are enabled |
| irq_pin_o | output | 1 | Interrupt pin output value |
| irq_pin_oe | output | 1 | Interrupt pin output enable |

## Verification
The bench targets the collision between an event and a clear on the same flag. A design that lets the clear win would drop that interrupt silently. It writes 81h and 3Fh against a populated register. A design that treats the whole byte as data, instead of as a mask, would wipe or set unrelated flags. It also writes FFh and checks that bits 6 and 7 never read back as 1. Finally, it cycles the pin through all four polarity and drive combinations. A swapped invert, or an open-drain stage that enables the pin while the level is high, would fight the external pull-up or report the wrong level.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned NSRC   = 6;

    // source bit positions within flag and enable registers
    localparam int unsigned SRC_LO_ALERT = 0;
    localparam int unsigned SRC_HI_ALERT = 1;
    localparam int unsigned SRC_IDLE     = 2;
    localparam int unsigned SRC_RX_END   = 3;
    localparam int unsigned SRC_TX_END   = 4;
    localparam int unsigned SRC_TIMER    = 5;

    typedef struct packed {
        logic drive_pp;   // 1: push-pull, 0: open-drain
        logic invert;     // 1: pin level inverted
    } pin_cfg_t;

    localparam pin_cfg_t PIN_CFG_RST = '{drive_pp: 1'b1, invert: 1'b0};
endpackage

// File: rtl/irq_setclr_reg.sv
`timescale 1ns/1ps
module irq_setclr_reg #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NBITS  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NBITS-1:0]  evt,
    output logic [NBITS-1:0]  q_bits
);
    localparam int unsigned SEL_BIT = DATA_W - 1;

    typedef struct packed {
        logic [NBITS-1:0] bits;
    } state_t;

    state_t st_d, st_q;
    logic [NBITS-1:0] nxt_bits;
    logic             set_sel;

    assign set_sel = wdata[SEL_BIT];

    generate
        if (SEL_BIT > NBITS) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^wdata[SEL_BIT-1:NBITS];
        end
        for (genvar g = 0; g < NBITS; g++) begin : g_bit
            logic hit;
            assign hit         = wr && wdata[g];
            assign nxt_bits[g] = evt[g] | (hit ? set_sel : st_q.bits[g]);
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.bits = nxt_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_bits = st_q.bits;

    assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[SEL_BIT]) |=>
        ((q_bits & $past(wdata[NBITS-1:0])) == $past(wdata[NBITS-1:0])));

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wdata[SEL_BIT]) |=>
        ((q_bits & $past(wdata[NBITS-1:0]) & ~$past(evt)) == '0));

    assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=>
        ((q_bits & ~$past(wdata[NBITS-1:0])) ==
         (($past(q_bits) | $past(evt)) & ~$past(wdata[NBITS-1:0]))));

    assert_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((q_bits & $past(evt)) == $past(evt)));

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && evt == '0) |=> $stable(q_bits));
endmodule

// File: rtl/irq_pin_drive.sv
`timescale 1ns/1ps
module irq_pin_drive
    import irq_pkg::*;
(
    input  logic     req,
    input  pin_cfg_t cfg,
    output logic     pin_o,
    output logic     pin_oe
);
    logic level;

    always_comb begin
        level = req ^ cfg.invert;
        if (cfg.drive_pp) begin
            pin_o  = level;
            pin_oe = 1'b1;
        end else begin
            pin_o  = 1'b0;
            pin_oe = ~level;
        end
    end
endmodule

// File: rtl/irq_req_ctrl.sv
`timescale 1ns/1ps
module irq_req_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned NS = NSRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_wr,
    input  logic          en_wr,
    input  logic          cfg_wr,
    input  logic [W-1:0]  wdata,
    input  logic [NS-1:0] evt,
    output logic [W-1:0]  req_rd,
    output logic [W-1:0]  en_rd,
    output logic [W-1:0]  cfg_rd,
    output logic          irq_global,
    output logic          irq_pin_o,
    output logic          irq_pin_oe
);
    localparam int unsigned PAD_W = W - NS;
    localparam int unsigned CFG_W = $bits(pin_cfg_t);

    logic [NS-1:0] req_bits, en_bits;
    pin_cfg_t      cfg_d, cfg_q;
    logic          unused_cfg_hi;

    irq_setclr_reg #(.DATA_W(W), .NBITS(NS)) u_req (
        .clk(clk), .rst_n(rst_n), .wr(req_wr), .wdata(wdata),
        .evt(evt), .q_bits(req_bits)
    );

    irq_setclr_reg #(.DATA_W(W), .NBITS(NS)) u_en (
        .clk(clk), .rst_n(rst_n), .wr(en_wr), .wdata(wdata),
        .evt('0), .q_bits(en_bits)
    );

    assign unused_cfg_hi = ^wdata[W-1:CFG_W];

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) cfg_d = pin_cfg_t'(wdata[CFG_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= PIN_CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign irq_global = |(req_bits & en_bits);

    irq_pin_drive u_pin (
        .req(irq_global), .cfg(cfg_q), .pin_o(irq_pin_o), .pin_oe(irq_pin_oe)
    );

    assign req_rd = {{PAD_W{1'b0}}, req_bits};
    assign en_rd  = {{PAD_W{1'b0}}, en_bits};
    assign cfg_rd = {{(W-CFG_W){1'b0}}, cfg_q};

    assert_hi_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_rd[W-1:NS] == '0);

    assert_pp_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd[1] |-> (irq_pin_oe && irq_pin_o == (irq_global ^ cfg_rd[0])));

    assert_od_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd[1] |-> (!irq_pin_o && irq_pin_oe == !(irq_global ^ cfg_rd[0])));

    assert_glob_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_global |-> (|(req_rd & en_rd)));
endmodule

// File: tb/sim_irq_req_ctrl.sv
`timescale 1ns/1ps
module sim_irq_req_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_wr = 1'b0, en_wr = 1'b0, cfg_wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [5:0] evt = 6'h00;
    logic [7:0] req_rd, en_rd, cfg_rd;
    logic       irq_global, irq_pin_o, irq_pin_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference state
    logic [5:0] m_req, m_en;
    logic [1:0] m_cfg;

    always #10 clk = ~clk;

    irq_req_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .en_wr(en_wr), .cfg_wr(cfg_wr),
        .wdata(wdata), .evt(evt), .req_rd(req_rd), .en_rd(en_rd), .cfg_rd(cfg_rd),
        .irq_global(irq_global), .irq_pin_o(irq_pin_o), .irq_pin_oe(irq_pin_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_req = 6'h00; m_en = 6'h00; m_cfg = 2'b10;
        end else begin
            for (int i = 0; i < 6; i++) begin
                if (req_wr && wdata[i]) m_req[i] = wdata[7];
                if (en_wr && wdata[i])  m_en[i]  = wdata[7];
            end
            m_req = m_req | evt;
            if (cfg_wr) m_cfg = wdata[1:0];
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            logic g, lvl, eo, eoe;
            g   = |(m_req & m_en);
            lvl = g ^ m_cfg[0];
            eo  = m_cfg[1] ? lvl : 1'b0;
            eoe = m_cfg[1] ? 1'b1 : ~lvl;
            chk("R1/R2/R6 req_rd", req_rd, {2'b00, m_req});
            chk("R7 en_rd", en_rd, {2'b00, m_en});
            chk("R9 cfg_rd", cfg_rd, {6'b0, m_cfg});
            chk("R8 irq_global", {7'b0, irq_global}, {7'b0, g});
            chk("R9/R10 pin", {6'b0, irq_pin_o, irq_pin_oe}, {6'b0, eo, eoe});
        end
    end

    task automatic wr1(input int sel, input logic [7:0] d, input logic [5:0] e);
        @(negedge clk);
        req_wr = (sel == 0); en_wr = (sel == 1); cfg_wr = (sel == 2);
        wdata = d; evt = e;
        @(negedge clk);
        req_wr = 0; en_wr = 0; cfg_wr = 0; evt = 6'h00;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        r = 32'h1234_abcd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R5 req reset", req_rd, 8'h00);
        chk("R5 en reset", en_rd, 8'h00);
        chk("R5 cfg reset", cfg_rd, 8'h02);
        chk("R5 pin reset", {6'b0, irq_pin_o, irq_pin_oe}, 8'h01);

        wr1(0, 8'h81, 6'h00);
        chk("R3 R11 write 81h", req_rd, 8'h01);
        wr1(0, 8'hBE, 6'h00);
        chk("R1 set mask", req_rd, 8'h3F);
        wr1(0, 8'h06, 6'h00);
        chk("R3 partial clear", req_rd, 8'h39);
        wr1(0, 8'h3F, 6'h00);
        chk("R2 clear all", req_rd, 8'h00);
        wr1(0, 8'hFF, 6'h00);
        chk("R4 bits 7:6 read zero", req_rd, 8'h3F);
        wr1(0, 8'h3F, 6'h00);
        wr1(0, 8'h00, 6'h20);
        chk("R4 R6 timer at bit5", req_rd, 8'h20);
        wr1(0, 8'h20, 6'h20);
        chk("R6 event beats clear", req_rd, 8'h20);
        wr1(0, 8'h00, 6'h01);
        chk("R4 R6 low alert at bit0", req_rd, 8'h21);
        chk("R8 disabled no global", {7'b0, irq_global}, 8'h00);
        wr1(1, 8'hA0, 6'h00);
        chk("R7 enable set", en_rd, 8'h20);
        chk("R8 global on", {7'b0, irq_global}, 8'h01);
        chk("R9 pp high", {6'b0, irq_pin_o, irq_pin_oe}, 8'h03);
        wr1(2, 8'h03, 6'h00);
        chk("R9 inverted", {6'b0, irq_pin_o, irq_pin_oe}, 8'h01);
        wr1(2, 8'h00, 6'h00);
        chk("R10 od released", {6'b0, irq_pin_o, irq_pin_oe}, 8'h00);
        wr1(2, 8'h01, 6'h00);
        chk("R10 od driven low", {6'b0, irq_pin_o, irq_pin_oe}, 8'h01);
        wr1(1, 8'h20, 6'h00);
        chk("R7 enable clear", en_rd, 8'h00);
        chk("R10 od released inv", {6'b0, irq_pin_o, irq_pin_oe}, 8'h00);
        wr1(2, 8'hFE, 6'h00);
        chk("R9 cfg hi bits zero", cfg_rd, 8'h02);

        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            req_wr = r[0] & r[1];
            en_wr  = r[2] & r[3];
            cfg_wr = r[4] & r[5] & r[6];
            wdata  = r[15:8];
            evt    = r[21:16] & r[27:22] & {6{r[28]}};
        end
        @(negedge clk);
        req_wr = 0; en_wr = 0; cfg_wr = 0; evt = 6'h00;
        repeat (2) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule